// File: doc/BRIEF.md
# DMA Descriptor Address Sequencer

This block walks the source and destination addresses of one DMA descriptor through a two-level transfer loop. A start strobe loads both start addresses and the two loop counts. Each transfer strobe then moves every address by a step. The step depends on that address's own 3-bit control code and on the transfer width. At the end of each inner loop, addresses whose code asks for it return to their start value.

When the last transfer of the job completes, the block looks at a 6-bit chain/return field. The inner and outer reload-mode flags choose one 2-bit slice of that field. The block then emits exactly one single-cycle result:
- an interrupt-flag pulse;
- a chain-start request for the current descriptor;
- a chain-start request for the next descriptor;
- a descriptor-open-error pulse;
- or nothing.

The open error covers two cases: a forbidden setting, and a case where the stored descriptor would need rewriting while write-back is disabled. Bus access, data movement, descriptor fetch and request arbitration belong to neighbouring blocks.

Top module: `dma_addr_seq`

## Requirements
- R1: After a synchronous active-low reset, both addresses read zero, `busy` is low and every result pulse is low.
- R2: A `start` strobe loads both start addresses, the inner count and the outer count, and raises `busy`. The addresses show their start values one cycle later. A count of zero is taken as one. `start` takes priority over a coincident `xfer`, and it restarts a job that is already running.
- R3: Each `xfer` while busy steps each address by its code: codes 000 and 001 add 1 unit, 010 and 011 add 2 units, 100 adds 4 units, 110 and 111 subtract 1 unit. The unit is 1, 2 or 4 bytes for width 00, 01 or 10, and width 11 acts as 4 bytes. Address arithmetic wraps modulo 2^32.
- R4: Code 101 keeps its address fixed for the whole job.
- R5: With inner reload on, codes 001, 011 and 111 bring their address back to its start value on the transfer that ends each inner loop. Codes 000, 010, 100 and 110 keep advancing.
- R6: With inner reload off, a job ends after inner-count transfers and the outer count is ignored. With inner reload on, a job ends after inner-count × outer-count transfers, and the inner count is restored at each inner-loop end.
- R7: The result slice is chosen by the reload flags:
  - bits [1:0] when inner reload is off (the outer flag is then ignored);
  - bits [3:2] when inner reload is on and outer reload is off;
  - bits [5:4] when both are on.

  Slice 00 gives no pulse, 01 pulses `irq_pulse`, 10 pulses `chain_next`, and 11 pulses `chain_cur`.
- R8: With both reload modes on, slice value 11 is forbidden. It pulses `open_err` and no chain request.
- R9: With `wb_disable` high, `open_err` pulses when either address does not keep its start value. An address keeps its start value when its code is 101, or when inner reload is on and its code is 001, 011 or 111. Whenever `open_err` pulses, the other three result pulses stay low.
- R10: Result pulses last one cycle and appear in the cycle after the edge that takes the final transfer, together with `busy` falling. At most one pulse is high at a time. While idle, `xfer` is ignored and the addresses hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load start addresses and counts, begin a job |
| xfer | input | 1 | One transfer completed |
| src_code | input | 3 | Source address control code |
| dst_code | input | 3 | Destination address control code |
| width | input | 2 | Transfer width: 00 byte, 01 halfword, 10 word |
| inner_reload | input | 1 | Inner reload mode |
| outer_reload | input | 1 | Outer reload mode |
| chrs | input | 6 | Chain/return field, three 2-bit slices |
| wb_disable | input | 1 | Descriptor write-back disabled |
| src_start | input | 32 | Source start address |
| dst_start | input | 32 | Destination start address |
| inner_count | input | 8 | Transfers per inner loop |
| outer_count | input | 8 | Number of inner loops |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| busy | output | 1 | Job in progress |
| irq_pulse | output | 1 | Interrupt-flag pulse |
| chain_next | output | 1 | Chain-start request, next descriptor |
| chain_cur | output | 1 | Chain-start request, current descriptor |
| open_err | output | 1 | Descriptor-open-error pulse |

## Verification
The assertions take for granted that codes, width, reload flags, the chain/return field and the write-back flag stay steady from `start` until the job ends. They also take for granted that `start` is never raised while reset is held. The stimulus sets all configuration once before each start strobe and changes it only between jobs. The single mid-job restart loads a new configuration together with the new start strobe.

// File: rtl/dma_seq_pkg.sv
// Package: shared encodings and small decode helpers for the DMA address
// sequencer. Assumes 3-bit address codes and a 2-bit width code.
package dma_seq_pkg;

    // Address control codes (same encoding for source and destination)
    typedef enum logic [2:0] {
        AC_INC1    = 3'b000,
        AC_INC1_RL = 3'b001,
        AC_INC2    = 3'b010,
        AC_INC2_RL = 3'b011,
        AC_INC4    = 3'b100,
        AC_FIXED   = 3'b101,
        AC_DEC1    = 3'b110,
        AC_DEC1_RL = 3'b111
    } addr_ctl_e;

    // End-of-job action held in one 2-bit slice of the chain/return field
    typedef enum logic [1:0] {
        ACT_NONE       = 2'b00,
        ACT_IRQ        = 2'b01,
        ACT_CHAIN_NEXT = 2'b10,
        ACT_CHAIN_CUR  = 2'b11
    } end_act_e;

    // True for codes that return to the start value at an inner-loop end
    function automatic logic is_reload_code(input logic [2:0] c);
        return (c == AC_INC1_RL) || (c == AC_INC2_RL) || (c == AC_DEC1_RL);
    endfunction

    // True for codes that move the address downward
    function automatic logic is_down_code(input logic [2:0] c);
        return (c == AC_DEC1) || (c == AC_DEC1_RL);
    endfunction

    // log2 of the width multiple selected by a code
    function automatic logic [1:0] mult_shift(input logic [2:0] c);
        case (c)
            AC_INC2, AC_INC2_RL: return 2'd1;
            AC_INC4:             return 2'd2;
            default:             return 2'd0;
        endcase
    endfunction

    // log2 of the byte size of one transfer unit (11 acts as word)
    function automatic logic [1:0] width_shift(input logic [1:0] w);
        case (w)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // True when the address ends the job equal to its start value
    function automatic logic keeps_start(input logic [2:0] c, input logic irm);
        return (c == AC_FIXED) || (irm && is_reload_code(c));
    endfunction

endpackage

// File: rtl/dma_addr_track.sv
// Address tracker: holds one address register and its start value. It steps
// the address per transfer according to its control code and the transfer
// width, and returns it to the start value on an inner-loop wrap for reload
// codes. Assumes code, width and reload flag are steady during a job.
module dma_addr_track
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic          advance,
    input  logic          inner_wrap,
    input  logic [2:0]    code,
    input  logic [1:0]    width,
    input  logic          inner_reload,
    output logic [AW-1:0] addr,
    output logic          keeps_start_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base_q;
    logic [AW-1:0] delta;
    logic [AW-1:0] next_addr;
    logic [2:0]    step_sh;

    // Byte step for this code and width; zero for the fixed code
    always_comb begin
        step_sh = {1'b0, width_shift(width)} + {1'b0, mult_shift(code)};
        delta   = (code == AC_FIXED) ? '0 : (ONE << step_sh);
    end

    // Next address: reload to base on a wrap, otherwise add or subtract
    always_comb begin
        if (inner_wrap && is_reload_code(code)) begin
            next_addr = base_q;
        end else if (is_down_code(code)) begin
            next_addr = addr - delta;
        end else begin
            next_addr = addr + delta;
        end
    end

    // Address and start-value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            base_q <= '0;
        end else if (load) begin
            addr   <= start_addr;
            base_q <= start_addr;
        end else if (advance) begin
            addr   <= next_addr;
        end
    end

    // Whether this address finishes the job at its start value
    always_comb keeps_start_o = keeps_start(code, inner_reload);

endmodule

// File: rtl/dma_loop_ctrl.sv
// Loop controller: runs the inner and outer transfer counters, flags
// inner-loop wraps and the final transfer, and holds the busy state.
// Assumes the reload flag is steady during a job. A zero count is taken
// as one.
module dma_loop_ctrl #(
    parameter int IW = 8,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          xfer,
    input  logic          inner_reload,
    input  logic [IW-1:0] inner_count,
    input  logic [OW-1:0] outer_count,
    output logic          busy,
    output logic          advance,
    output logic          inner_wrap,
    output logic          final_xfer
);

    logic [IW-1:0] in_left;
    logic [IW-1:0] in_init;
    logic [OW-1:0] out_left;
    logic [IW-1:0] in_eff;
    logic [OW-1:0] out_eff;
    logic          inner_last;
    logic          outer_last;

    // Effective counts with zero promoted to one
    always_comb begin
        in_eff  = (inner_count == '0) ? IW'(1) : inner_count;
        out_eff = (outer_count == '0) ? OW'(1) : outer_count;
    end

    // Transfer qualification and loop-end detection
    always_comb begin
        inner_last = (in_left == IW'(1));
        outer_last = (out_left == OW'(1));
        advance    = busy && xfer && !load;
        inner_wrap = advance && inner_last && inner_reload;
        final_xfer = advance && inner_last && (!inner_reload || outer_last);
    end

    // Counter and busy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            in_left  <= '0;
            in_init  <= '0;
            out_left <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            in_left  <= in_eff;
            in_init  <= in_eff;
            out_left <= out_eff;
        end else if (advance) begin
            if (final_xfer) begin
                busy     <= 1'b0;
            end else if (inner_last) begin
                in_left  <= in_init;
                out_left <= out_left - OW'(1);
            end else begin
                in_left  <= in_left - IW'(1);
            end
        end
    end

endmodule

// File: rtl/dma_end_action.sv
// End-of-job action decoder: picks the chain/return slice from the reload
// flags, detects open-error conditions and registers one single-cycle result
// pulse when the final transfer fires. An open error masks every other action.
module dma_end_action
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [5:0] chrs,
    input  logic       inner_reload,
    input  logic       outer_reload,
    input  logic       wb_disable,
    input  logic       src_keeps,
    input  logic       dst_keeps,
    output logic       irq_pulse,
    output logic       chain_next,
    output logic       chain_cur,
    output logic       open_err
);

    end_act_e act;
    logic     forbidden;
    logic     wb_err;
    logic     any_err;

    // Slice selection by reload mode
    always_comb begin
        if (!inner_reload) begin
            act = end_act_e'(chrs[1:0]);
        end else if (!outer_reload) begin
            act = end_act_e'(chrs[3:2]);
        end else begin
            act = end_act_e'(chrs[5:4]);
        end
    end

    // Error conditions: forbidden slice value or a needed rewrite with write-back off
    always_comb begin
        forbidden = inner_reload && outer_reload && (act == ACT_CHAIN_CUR);
        wb_err    = wb_disable && !(src_keeps && dst_keeps);
        any_err   = forbidden || wb_err;
    end

    // Registered single-cycle result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse  <= 1'b0;
            chain_next <= 1'b0;
            chain_cur  <= 1'b0;
            open_err   <= 1'b0;
        end else begin
            irq_pulse  <= fire && !any_err && (act == ACT_IRQ);
            chain_next <= fire && !any_err && (act == ACT_CHAIN_NEXT);
            chain_cur  <= fire && !any_err && (act == ACT_CHAIN_CUR);
            open_err   <= fire && any_err;
        end
    end

endmodule

// File: rtl/dma_addr_seq.sv
// Top: DMA descriptor address sequencer. Ties two address trackers (source,
// destination), the loop controller and the end-action decoder together.
// Assumes configuration inputs are steady from start until the job ends.
module dma_addr_seq #(
    parameter int AW = 32,
    parameter int IW = 8,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          xfer,
    input  logic [2:0]    src_code,
    input  logic [2:0]    dst_code,
    input  logic [1:0]    width,
    input  logic          inner_reload,
    input  logic          outer_reload,
    input  logic [5:0]    chrs,
    input  logic          wb_disable,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [IW-1:0] inner_count,
    input  logic [OW-1:0] outer_count,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          busy,
    output logic          irq_pulse,
    output logic          chain_next,
    output logic          chain_cur,
    output logic          open_err
);

    localparam int NCH = 2;

    logic                   advance;
    logic                   inner_wrap;
    logic                   final_xfer;
    logic [NCH-1:0][2:0]    codes;
    logic [NCH-1:0][AW-1:0] starts;
    logic [NCH-1:0][AW-1:0] addrs;
    logic [NCH-1:0]         keeps;

    // Pack per-channel inputs: index 0 source, index 1 destination
    always_comb begin
        codes[0]  = src_code;
        codes[1]  = dst_code;
        starts[0] = src_start;
        starts[1] = dst_start;
        src_addr  = addrs[0];
        dst_addr  = addrs[1];
    end

    dma_loop_ctrl #(.IW(IW), .OW(OW)) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (start),
        .xfer         (xfer),
        .inner_reload (inner_reload),
        .inner_count  (inner_count),
        .outer_count  (outer_count),
        .busy         (busy),
        .advance      (advance),
        .inner_wrap   (inner_wrap),
        .final_xfer   (final_xfer)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_addr
        dma_addr_track #(.AW(AW)) u_trk (
            .clk           (clk),
            .rst_n         (rst_n),
            .load          (start),
            .start_addr    (starts[g]),
            .advance       (advance),
            .inner_wrap    (inner_wrap),
            .code          (codes[g]),
            .width         (width),
            .inner_reload  (inner_reload),
            .addr          (addrs[g]),
            .keeps_start_o (keeps[g])
        );
    end

    dma_end_action u_act (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (final_xfer),
        .chrs         (chrs),
        .inner_reload (inner_reload),
        .outer_reload (outer_reload),
        .wb_disable   (wb_disable),
        .src_keeps    (keeps[0]),
        .dst_keeps    (keeps[1]),
        .irq_pulse    (irq_pulse),
        .chain_next   (chain_next),
        .chain_cur    (chain_cur),
        .open_err     (open_err)
    );

endmodule

// File: rtl/dma_addr_seq_chk.sv
// Checker for dma_addr_seq: temporal properties on its ports, attached by bind.
// Assumes configuration inputs are steady during a job.
module dma_addr_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    src_code,
    input logic          inner_reload,
    input logic          outer_reload,
    input logic [AW-1:0] src_start,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic          busy,
    input logic          irq_pulse,
    input logic          chain_next,
    input logic          chain_cur,
    input logic          open_err
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (!busy && src_addr == '0 && dst_addr == '0));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(rst_n)) |-> (busy && src_addr == $past(src_start)));

    // R4
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(start) && src_code == 3'b101 && $past(src_code) == 3'b101)
        |-> $stable(src_addr));

    // R8
    no_forbidden_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_cur |-> !(inner_reload && outer_reload));

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_pulse, chain_next, chain_cur, open_err}));

    // R10
    result_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse || chain_next || chain_cur || open_err) |-> (!busy && $past(busy)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(start)) |-> ($stable(src_addr) && $stable(dst_addr)));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .src_code     (src_code),
    .inner_reload (inner_reload),
    .outer_reload (outer_reload),
    .src_start    (src_start),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .busy         (busy),
    .irq_pulse    (irq_pulse),
    .chain_next   (chain_next),
    .chain_cur    (chain_cur),
    .open_err     (open_err)
);

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        xfer = 1'b0;
    logic [2:0]  sc = '0, dc = '0;
    logic [1:0]  w = '0;
    logic        irm = 1'b0, orm = 1'b0, wb = 1'b0;
    logic [5:0]  ch = '0;
    logic [31:0] ss = '0, ds = '0;
    logic [7:0]  ic = 8'd1, oc = 8'd1;
    logic [31:0] src_addr, dst_addr;
    logic        busy, irq_pulse, chain_next, chain_cur, open_err;

    always #2.5 clk = ~clk;

    dma_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer),
        .src_code(sc), .dst_code(dc), .width(w),
        .inner_reload(irm), .outer_reload(orm), .chrs(ch), .wb_disable(wb),
        .src_start(ss), .dst_start(ds), .inner_count(ic), .outer_count(oc),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
        .irq_pulse(irq_pulse), .chain_next(chain_next),
        .chain_cur(chain_cur), .open_err(open_err)
    );

    typedef struct {
        logic [31:0] src;
        logic [31:0] dst;
        logic [3:0]  res;   // {irq, chain_next, chain_cur, open_err}
        string       tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        got;
    int          checks = 0;
    int          errors = 0;
    logic        prev_busy = 1'b0;
    logic [31:0] m_src, m_dst;
    int          m_i, ice, oce;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference step from R3/R4
    function automatic logic [31:0] adv(input logic [31:0] a, input logic [2:0] c,
                                        input logic [1:0] wc);
        logic [31:0] u;
        u = (wc == 2'b00) ? 32'd1 : (wc == 2'b01) ? 32'd2 : 32'd4;
        case (c)
            3'd0, 3'd1: return a + u;
            3'd2, 3'd3: return a + 2 * u;
            3'd4:       return a + 4 * u;
            3'd5:       return a;
            default:    return a - u;
        endcase
    endfunction

    function automatic bit rl(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd3) || (c == 3'd7);
    endfunction

    function automatic bit keep(input logic [2:0] c, input logic r);
        return (c == 3'd5) || (r && rl(c));
    endfunction

    // Reference final address from R3, R5, R6
    function automatic logic [31:0] final_addr(input logic [31:0] s, input logic [2:0] c);
        logic [31:0] a;
        a = s;
        for (int o = 0; o < (irm ? oce : 1); o++) begin
            for (int i = 0; i < ice; i++) begin
                a = adv(a, c, w);
                if (i == ice - 1 && irm && rl(c)) a = s;
            end
        end
        return a;
    endfunction

    task automatic cfg(input logic [2:0] sc_, input logic [2:0] dc_, input logic [1:0] w_,
                       input logic irm_, input logic orm_, input logic [5:0] ch_,
                       input logic wb_, input logic [31:0] ss_, input logic [31:0] ds_,
                       input logic [7:0] ic_, input logic [7:0] oc_);
        sc = sc_; dc = dc_; w = w_; irm = irm_; orm = orm_; ch = ch_;
        wb = wb_; ss = ss_; ds = ds_; ic = ic_; oc = oc_;
    endtask

    // Driver: pushes the expected end result, then issues start (R2)
    task automatic begin_job(input string tag, input bit push, input bit with_xfer);
        logic [1:0] sl;
        bit         err;
        exp_t       e;
        ice = (ic == 0) ? 1 : int'(ic);
        oce = (oc == 0) ? 1 : int'(oc);
        if (push) begin
            sl  = !irm ? ch[1:0] : (!orm ? ch[3:2] : ch[5:4]);
            err = (irm && orm && sl == 2'b11) || (wb && !(keep(sc, irm) && keep(dc, irm)));
            e.src = final_addr(ss, sc);
            e.dst = final_addr(ds, dc);
            e.res = err ? 4'b0001 : {sl == 2'b01, sl == 2'b10, sl == 2'b11, 1'b0};
            e.tag = tag;
            sb.push_back(e);
        end
        m_src = ss; m_dst = ds; m_i = ice;
        start = 1'b1;
        xfer  = with_xfer;
        @(negedge clk);
        start = 1'b0;
        xfer  = 1'b0;
        check(src_addr == ss, "R2", "start src", src_addr, ss);
        check(dst_addr == ds && busy, "R2", "start dst", dst_addr, ds);
    endtask

    // Driver: n transfers, checking both addresses after each (R3, R5)
    task automatic do_xfers(input int n, input int gap, input string tag);
        for (int k = 0; k < n; k++) begin
            xfer = 1'b1;
            @(negedge clk);
            if (gap > 0) xfer = 1'b0;
            m_src = adv(m_src, sc, w);
            m_dst = adv(m_dst, dc, w);
            if (m_i == 1) begin
                if (irm && rl(sc)) m_src = ss;
                if (irm && rl(dc)) m_dst = ds;
                m_i = ice;
            end else begin
                m_i--;
            end
            check(src_addr == m_src, tag, "step src", src_addr, m_src);
            check(dst_addr == m_dst, tag, "step dst", dst_addr, m_dst);
            repeat (gap) @(negedge clk);
        end
        xfer = 1'b0;
    endtask

    task automatic run(input string tag, input int gap);
        begin_job(tag, 1'b1, 1'b0);
        do_xfers(ice * (irm ? oce : 1), gap, tag);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops the expected result when busy falls (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy && !busy) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected job end", 32'd1, 32'd0);
                end else begin
                    got = sb.pop_front();
                    check(src_addr == got.src, got.tag, "final src", src_addr, got.src);
                    check(dst_addr == got.dst, got.tag, "final dst", dst_addr, got.dst);
                    check({irq_pulse, chain_next, chain_cur, open_err} == got.res, got.tag,
                          "result {irq,next,cur,err}",
                          {28'd0, irq_pulse, chain_next, chain_cur, open_err}, {28'd0, got.res});
                end
            end else if (irq_pulse || chain_next || chain_cur || open_err) begin
                check(1'b0, "R10", "stray pulse",
                      {28'd0, irq_pulse, chain_next, chain_cur, open_err}, 32'd0);
            end
        end
        prev_busy <= busy;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] hs, hd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && src_addr == 0 && dst_addr == 0, "R1", "reset addr/busy",
              src_addr | dst_addr, 32'd0);
        check({irq_pulse, chain_next, chain_cur, open_err} == 4'b0, "R1", "reset pulses",
              {28'd0, irq_pulse, chain_next, chain_cur, open_err}, 32'd0);

        // R3 R7: byte up by 1 and 2, slice [1:0]=01 -> irq
        cfg(3'd0, 3'd2, 2'b00, 1'b0, 1'b0, 6'b000001, 1'b0, 32'h1000, 32'h2000, 8'd4, 8'd1);
        run("R3", 0);
        // R3 wrap: word, up by 4x and down; chain next
        cfg(3'd4, 3'd6, 2'b10, 1'b0, 1'b0, 6'b000010, 1'b0, 32'hFFFF_FFF0, 32'h4, 8'd3, 8'd1);
        run("R3", 1);
        // R5 R6 R7: halfword reload codes, slice [3:2]=11 -> chain current
        cfg(3'd1, 3'd3, 2'b01, 1'b1, 1'b0, 6'b001100, 1'b0, 32'h100, 32'h800, 8'd3, 8'd2);
        run("R5", 0);
        // R6 R7: both reloads, slice [5:4]=10 -> chain next; non-reload keeps going
        cfg(3'd0, 3'd7, 2'b00, 1'b1, 1'b1, 6'b100011, 1'b0, 32'h40, 32'h80, 8'd2, 8'd3);
        run("R6", 1);
        // R8 forbidden 11 in [5:4]
        cfg(3'd1, 3'd1, 2'b00, 1'b1, 1'b1, 6'b110000, 1'b0, 32'h10, 32'h20, 8'd2, 8'd2);
        run("R8", 0);
        // R4 R9: fixed and reload codes keep start -> no error with write-back off
        cfg(3'd5, 3'd1, 2'b10, 1'b1, 1'b0, 6'b000100, 1'b1, 32'h300, 32'h500, 8'd3, 8'd2);
        run("R4", 0);
        // R9: advancing code with write-back off -> error, irq masked
        cfg(3'd0, 3'd5, 2'b00, 1'b0, 1'b0, 6'b000001, 1'b1, 32'h600, 32'h700, 8'd2, 8'd1);
        run("R9", 0);
        // R9: reload code without inner reload -> error
        cfg(3'd1, 3'd5, 2'b01, 1'b0, 1'b0, 6'b000010, 1'b1, 32'h900, 32'hA00, 8'd3, 8'd1);
        run("R9", 1);
        // R7: outer flag ignored with inner reload off; R3 width 11 acts as word
        cfg(3'd2, 3'd6, 2'b11, 1'b0, 1'b1, 6'b111101, 1'b0, 32'hB00, 32'hC00, 8'd2, 8'd5);
        run("R7", 0);
        // R2: zero counts act as one transfer
        cfg(3'd0, 3'd0, 2'b10, 1'b1, 1'b0, 6'b000100, 1'b0, 32'hD00, 32'hE00, 8'd0, 8'd0);
        run("R2", 0);

        // R2: restart while busy, start beats a coincident xfer
        cfg(3'd0, 3'd0, 2'b00, 1'b0, 1'b0, 6'b000001, 1'b0, 32'h50, 32'h60, 8'd10, 8'd1);
        begin_job("R2", 1'b0, 1'b0);
        do_xfers(3, 0, "R2");
        cfg(3'd6, 3'd0, 2'b01, 1'b0, 1'b0, 6'b000010, 1'b0, 32'h1234, 32'h5678, 8'd2, 8'd1);
        begin_job("R2", 1'b1, 1'b1);
        do_xfers(2, 0, "R2");
        repeat (2) @(negedge clk);

        // R10: xfer while idle is ignored
        hs = src_addr;
        hd = dst_addr;
        xfer = 1'b1;
        repeat (3) @(negedge clk);
        xfer = 1'b0;
        @(negedge clk);
        check(src_addr == hs, "R10", "idle src", src_addr, hs);
        check(dst_addr == hd && !busy, "R10", "idle dst", dst_addr, hd);

        check(sb.size() == 0, "R10", "pending results", sb.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule